// File: doc/BRIEF.md
# Noise-Shaped Phase Sine Synthesizer

This block is the digital core of a direct frequency synthesizer. A 16-bit phase register advances by a programmable step on each enabled clock. Its top 12 bits are then requantized to 8 bits, and those 8 bits address a 256-entry sine lookup table that returns a 12-bit two's complement amplitude. Plain truncation would throw the dropped bits away as a periodic error. Here a single-stage fourth-order error-feedback loop pushes that error toward high frequencies, so the table can be sixteen times smaller than a 12-bit-addressed table without the periodic spurs.

The block produces one output sample for every clock on which the enable is high. The sample appears three clocks later and is flagged by a valid strobe. The output is fully determined by the sequence of steps applied since the last synchronous reset.

Top module: `dds_shaped_top`

## Requirements
- R1: The 16-bit phase register adds `ftw_i` modulo 2^16 on every clock where `en_i` is high and holds its value otherwise; each output sample is derived from the register value just after its own addition.
- R2: The requantizer takes x = phase register bits [15:4] and forms s = x + 4·e1 − 6·e2 + 4·e3 − e4, where e1..e4 are the four most recent error values (e1 newest). The 8-bit table address is floor(s/16) mod 256, and the new error is s mod 16 (0..15).
- R3: The sum s is formed with signed guard bits and never overflows; it always lies in [−120, 4215].
- R4: Table entry k (0..255) equals round(2047·sin(2πk/256)), stored in 12-bit two's complement, so that entry 64 is +2047, entry 192 is −2047 and entries 0 and 128 are 0.
- R5: `valid_o` is high on the third clock after each clock with `en_i` high and is low otherwise; `sample_o` changes only together with a valid strobe.
- R6: Synchronous reset clears the phase register, all error history, the pipeline, `valid_o` and `sample_o`.
- R7: With a zero step after reset, every output sample is 0.
- R8: The same step and enable sequence after any reset yields a bit-identical sample sequence.
- R9: The running sum of (8-bit address · 16 − x), taken as a signed 12-bit difference, stays within ±64, so the mean shaped phase tracks the unshaped 12-bit phase to within one output LSB over eight or more steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance the phase and emit one sample |
| ftw_i | input | 16 | Phase step per enabled clock |
| sample_o | output | 12 | Signed sine amplitude |
| valid_o | output | 1 | Sample strobe, three clocks after the enable |

## Verification
The assertions assume that `rst` is held high from time zero for at least one clock. They also assume that `en_i` and `ftw_i` change only between clock edges. The bench drives both inputs on the falling edge and starts every test sequence with a multi-cycle reset. The latency properties need no assumption about how the enable is patterned, so the stimulus mixes random enable gaps with random step values across the whole 16-bit range. This range includes steps whose low four bits are nonzero, which exercise the error-feedback path.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded, symmetric sine code for table slot idx out of depth slots.
  function automatic int sine_code(input int idx, input int depth, input int peak);
    real a;
    a = $sin(TWO_PI * idx / depth) * peak;
    if (a >= 0.0) return $rtoi(a + 0.5);
    else return -$rtoi(0.5 - a);
  endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);

  always_ff @(posedge clk) begin
    if (rst) acc_o <= '0;
    else if (step_i) acc_o <= acc_o + inc_i;
  end

endmodule

// File: rtl/phase_shaper.sv
module phase_shaper #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8,
  parameter int GUARD = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [IN_W-1:0]  x_i,
  output logic [OUT_W-1:0] phase_o
);

  localparam int DROP  = IN_W - OUT_W;
  localparam int SUM_W = IN_W + GUARD;
  localparam int TAPS  = 4;

  logic [DROP-1:0]         err_q [TAPS];
  logic signed [SUM_W-1:0] fb_w;
  logic signed [SUM_W-1:0] sum_w;

  function automatic logic signed [SUM_W-1:0] widen(input logic [DROP-1:0] e);
    return signed'({{(SUM_W-DROP){1'b0}}, e});
  endfunction

  // Error feedback realizing a (1 - z^-1)^4 noise transfer.
  always_comb begin
    fb_w  = (widen(err_q[0]) <<< 2)
          - (widen(err_q[1]) <<< 2) - (widen(err_q[1]) <<< 1)
          + (widen(err_q[2]) <<< 2)
          - widen(err_q[3]);
    sum_w = signed'({{(SUM_W-IN_W){1'b0}}, x_i}) + fb_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= '0;
      for (int i = 0; i < TAPS; i++) err_q[i] <= '0;
    end else if (step_i) begin
      phase_o  <= sum_w[DROP +: OUT_W];
      err_q[0] <= sum_w[DROP-1:0];
      for (int i = 1; i < TAPS; i++) err_q[i] <= err_q[i-1];
    end
  end

endmodule

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [AMP_W-1:0] data_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = AMP_W'(dds_pkg::sine_code(i, DEPTH, PEAK));
  end

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else if (rd_i) data_o <= mem[addr_i];
  end

endmodule

// File: rtl/dds_shaped_top.sv
module dds_shaped_top #(
  parameter int ACC_W = 16,
  parameter int SHP_W = 12,
  parameter int PH_W  = 8,
  parameter int AMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic [ACC_W-1:0]        ftw_i,
  output logic signed [AMP_W-1:0] sample_o,
  output logic                    valid_o
);

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase_q;
  logic             st1_q, st2_q;

  phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .step_i(en_i), .inc_i(ftw_i), .acc_o(acc_q)
  );

  phase_shaper #(.IN_W(SHP_W), .OUT_W(PH_W)) u_shp (
    .clk(clk), .rst(rst), .step_i(st1_q),
    .x_i(acc_q[ACC_W-1 -: SHP_W]), .phase_o(phase_q)
  );

  sine_rom #(.ADDR_W(PH_W), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst(rst), .rd_i(st2_q), .addr_i(phase_q), .data_o(sample_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_q   <= 1'b0;
      st2_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      st1_q   <= en_i;
      st2_q   <= st1_q;
      valid_o <= st2_q;
    end
  end

endmodule

// File: rtl/dds_shaped_chk.sv
module dds_shaped_chk #(
  parameter int ACC_W = 16,
  parameter int SHP_W = 12,
  parameter int PH_W  = 8,
  parameter int AMP_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [ACC_W-1:0]        ftw,
  input logic [ACC_W-1:0]        acc,
  input logic                    shp_step,
  input logic [PH_W-1:0]         phase,
  input logic signed [AMP_W-1:0] sample,
  input logic                    valid
);

  localparam int DROP = SHP_W - PH_W;
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;

  logic                    armed;
  logic                    pend;
  logic [SHP_W-1:0]        x_hold;
  logic signed [SHP_W-1:0] diff;
  int                      cum;

  assign diff = signed'({phase, {DROP{1'b0}}} - x_hold);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      pend   <= 1'b0;
      x_hold <= '0;
      cum    <= 0;
    end else begin
      armed <= 1'b1;
      pend  <= shp_step;
      if (shp_step) x_hold <= acc[ACC_W-1 -: SHP_W];
      if (pend) cum <= cum + int'(diff);
    end
  end

  p_acc_add_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    en |=> acc == $past(acc) + $past(ftw));
  p_acc_hold_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    !en |=> $stable(acc));
  p_lat_on_r5: assert property (@(posedge clk) disable iff (rst)
    en |-> ##3 valid);
  p_lat_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en |-> ##3 !valid);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    !valid |-> $stable(sample));
  p_range_r4: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(sample) <= PEAK && int'(sample) >= -PEAK));
  p_clear_r6: assert property (@(posedge clk)
    rst |=> (acc == '0 && !valid && sample == '0));
  p_mean_track_r9: assert property (@(posedge clk) disable iff (rst)
    (cum <= 64 && cum >= -64));

endmodule

module dds_shaper_chk #(
  parameter int IN_W  = 12,
  parameter int DROP  = 4,
  parameter int SUM_W = 15
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [SUM_W-1:0] sum
);

  localparam int FB_MAX = 8 * ((1 << DROP) - 1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(sum) >= -FB_MAX && int'(sum) <= (1 << IN_W) - 1 + FB_MAX));

endmodule

bind dds_shaped_top dds_shaped_chk #(
  .ACC_W(ACC_W), .SHP_W(SHP_W), .PH_W(PH_W), .AMP_W(AMP_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en_i), .ftw(ftw_i), .acc(acc_q),
  .shp_step(st1_q), .phase(phase_q), .sample(sample_o), .valid(valid_o)
);

bind phase_shaper dds_shaper_chk #(
  .IN_W(IN_W), .DROP(DROP), .SUM_W(SUM_W)
) u_schk (
  .clk(clk), .rst(rst), .sum(sum_w)
);

// File: tb/dds_shaped_top_tb.sv
module dds_shaped_top_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst = 1'b1;
  logic               en  = 1'b0;
  logic [15:0]        ftw = '0;
  logic signed [11:0] sample;
  logic               valid;

  dds_shaped_top u_dut (
    .clk(clk), .rst(rst), .en_i(en), .ftw_i(ftw),
    .sample_o(sample), .valid_o(valid)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int tbl [256];
  function automatic int ref_sine(input int k);
    real a;
    a = 2047.0 * $sin(6.283185307179586 * k / 256.0);
    if (a >= 0.0) return $rtoi(a + 0.5);
    return -$rtoi(0.5 - a);
  endfunction

  // Reference model, advanced once per rising edge.
  logic [15:0] m_acc;
  int m_e [4];
  int m_ph, m_sample, m_cum, m_cum_peak, m_smin, m_smax;
  bit m_v1, m_v2, m_valid;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_ph = 0; m_sample = 0; m_cum = 0;
      m_v1 = 0; m_v2 = 0; m_valid = 0;
      for (int i = 0; i < 4; i++) m_e[i] = 0;
    end else begin
      if (m_v2) m_sample = tbl[m_ph];
      m_valid = m_v2;
      m_v2 = m_v1;
      if (m_v1) begin
        int x, s, nph, d;
        x = int'(m_acc[15:4]);
        s = x + 4*m_e[0] - 6*m_e[1] + 4*m_e[2] - m_e[3];
        if (s < m_smin) m_smin = s;
        if (s > m_smax) m_smax = s;
        nph = (s >>> 4) & 255;
        d = nph*16 - x;
        if (d > 2047) d -= 4096;
        if (d < -2048) d += 4096;
        m_cum += d;
        if (m_cum > m_cum_peak) m_cum_peak = m_cum;
        if (-m_cum > m_cum_peak) m_cum_peak = -m_cum;
        m_e[3] = m_e[2]; m_e[2] = m_e[1]; m_e[1] = m_e[0];
        m_e[0] = s & 15;
        m_ph = nph;
      end
      m_v1 = en;
      if (en) m_acc = m_acc + ftw;
    end
  end

  // Cycle scoreboard and sample capture.
  int got [0:1023];
  int ng = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(valid == m_valid, "R5 valid timing", int'(valid), int'(m_valid));
      if (m_valid) check(int'(sample) == m_sample, "R2 sample vs model", int'(sample), m_sample);
      if (valid && ng < 1024) begin
        got[ng] = int'(sample);
        ng++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ng = 0;
  endtask

  task automatic run(input logic [15:0] step, input int n);
    ftw = step;
    en  = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  int first [0:63];
  int first_n;

  initial begin
    m_smin = 0; m_smax = 0; m_cum_peak = 0;
    for (int k = 0; k < 256; k++) tbl[k] = ref_sine(k);
    void'($urandom(32'd2024));

    // R6: reset state
    do_reset();
    check(valid == 1'b0, "R6 valid after reset", int'(valid), 0);
    check(sample == '0, "R6 sample after reset", int'(sample), 0);

    // R7: zero step gives a constant zero sample
    run(16'h0000, 20);
    check(ng == 20, "R7 sample count", ng, 20);
    for (int i = 0; i < 20; i++) check(got[i] == 0, "R7 constant sample", got[i], 0);

    // R4: quarter-period steps hit the table extremes
    do_reset();
    run(16'h4000, 4);
    check(got[0] == 2047, "R4 entry 64", got[0], 2047);
    check(got[1] == 0, "R4 entry 128", got[1], 0);
    check(got[2] == -2047, "R4 entry 192", got[2], -2047);
    check(got[3] == 0, "R4 entry 0", got[3], 0);

    // R1: step of one address per clock, then hold while disabled
    do_reset();
    run(16'h0100, 6);
    for (int i = 0; i < 6; i++) check(got[i] == tbl[i+1], "R1 linear phase", got[i], tbl[i+1]);
    repeat (5) @(negedge clk);
    check(ng == 6, "R5 no sample while idle", ng, 6);
    run(16'h0100, 1);
    check(got[6] == tbl[7], "R1 phase held across idle", got[6], tbl[7]);

    // R5: single enable pulse gives valid on the third clock
    begin
      int seen;
      seen = 0;
      en = 1'b1; ftw = 16'h0123;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (k == 1) en = 1'b0;
        if (valid && seen == 0) seen = k;
      end
      check(seen == 3, "R5 latency", seen, 3);
    end

    // R8: repeatability after reset
    do_reset();
    run(16'h1235, 30);
    first_n = ng;
    for (int i = 0; i < 30; i++) first[i] = got[i];
    do_reset();
    run(16'h1235, 30);
    check(ng == first_n, "R8 sample count", ng, first_n);
    for (int i = 0; i < 30; i++) check(got[i] == first[i], "R8 repeat", got[i], first[i]);

    // Random steps and enable gaps, checked by the scoreboard (R2, R5)
    do_reset();
    for (int blk = 0; blk < 40; blk++) begin
      ftw = 16'($urandom);
      for (int c = 0; c < 25; c++) begin
        en = ($urandom % 4) != 0;
        @(negedge clk);
      end
    end
    en = 1'b0;
    repeat (4) @(negedge clk);

    // R3 and R9 on the requantized phase stream
    check(m_smin >= -120, "R3 sum lower bound", m_smin, -120);
    check(m_smax <= 4215, "R3 sum upper bound", m_smax, 4215);
    check(m_cum_peak <= 64, "R9 running phase error", m_cum_peak, 64);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule